// File: doc/BRIEF.md
# Serial Line Idle Status Detector

This block watches a serial receive line, already sampled at the bit rate, and reports whether the line is idle. It also reports the state of the carrier-detect and clear-to-send modem lines. A bit-rate strobe marks the cycles that carry a valid received bit. On each strobed cycle a run counter counts consecutive ones. A zero restarts the count. The line is called idle once the run reaches a mode-dependent length: a fixed run of fifteen ones for bit-synchronous HDLC framing, or one whole idle character for asynchronous UART framing. The UART character length is programmable from 9 to 13 bit times.

The two modem pins pass through a synchronizer. They are then reported with the pins' own polarity, unless a multiplexed line mode is selected, in which case they read zero. In normal diagnostic mode, carrier detect gates idle status: with no carrier the idle bit reads one whatever the line does. In software-control mode the carrier pin plays no part in idle status. The receive and transmit enables gate the status bits. Each time one of the three status bits changes, a pulse lasting one clock cycle is raised.

Top module: `line_idle_status`

## Requirements
- R1: With mode_sel=0 (HDLC), idle_stat becomes 1 on the clock after the edge that samples the fifteenth consecutive strobed one. After only fourteen ones it is still 0.
- R2: In either mode, a strobed zero clears the run. idle_stat then reads 0 on the next clock unless carrier gating forces it. HDLC flags (01111110) repeated on the line therefore keep idle_stat at 0.
- R3: With mode_sel=1 (UART), the idle run length equals char_len (binary). Values below 9 are treated as 9 and values above 13 are treated as 13.
- R4: The run counter advances only on cycles with bit_en=1. It saturates at the threshold, so further ones keep idle_stat at 1.
- R5: With diag_soft=0 (normal) and rx_enable=1, a deasserted synchronized carrier forces idle_stat to 1.
- R6: With diag_soft=1 (software control), idle_stat follows line activity only, whatever the level on cd_pin.
- R7: cd_stat and cts_stat carry the pin polarity through a two-flop synchronizer plus the status register, so a pin change appears on the third rising edge. Both bits read 0 while mux_mode=1.
- R8: All outputs are 0 after reset. While rx_enable=0, idle_stat and cd_stat read 0 and the run counter is held at zero. While tx_enable=0, cts_stat reads 0.
- R9: stat_change is 1 for exactly the cycles in which {idle_stat, cd_stat, cts_stat} differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate strobe; rx_bit is valid when high |
| rx_bit | input | 1 | Sampled received data bit |
| cd_pin | input | 1 | Raw carrier-detect pin (asynchronous) |
| cts_pin | input | 1 | Raw clear-to-send pin (asynchronous) |
| mode_sel | input | 1 | 0 = HDLC run criterion, 1 = UART character criterion |
| diag_soft | input | 1 | 0 = normal (carrier gates idle), 1 = software control |
| char_len | input | 4 | UART idle character length in bit times (9..13) |
| mux_mode | input | 1 | Multiplexed line mode; forces modem bits to 0 |
| rx_enable | input | 1 | Receiver enable |
| tx_enable | input | 1 | Transmitter enable |
| idle_stat | output | 1 | Line idle status |
| cd_stat | output | 1 | Carrier-detect status |
| cts_stat | output | 1 | Clear-to-send status |
| stat_change | output | 1 | One-cycle pulse when any status bit changes |

## Verification
Some properties are checked on every cycle by assertions. These are:
- a strobed zero empties the run counter;
- the counter holds still without a strobe and does not wrap once saturated;
- a disabled receiver keeps the counter and its status bits at zero;
- multiplexed mode silences the modem bits;
- a missing carrier forces idle in normal mode;
- the change pulse agrees with status transitions in both directions.

Other behaviour shows only in the bench's scenarios. This covers the exact run lengths (fifteen for HDLC, the clamped character length for UART), the flag pattern that never lets the line go idle, the three-edge latency of the modem pins, and the difference between normal and software diagnostic handling of carrier.

// File: rtl/line_status_pkg.sv
package line_status_pkg;

    typedef enum logic {
        LINE_HDLC = 1'b0,
        LINE_UART = 1'b1
    } line_mode_e;

    typedef enum logic {
        DIAG_NORMAL = 1'b0,
        DIAG_SOFT   = 1'b1
    } diag_mode_e;

    typedef struct packed {
        logic idle;
        logic cd;
        logic cts;
    } line_status_t;

    localparam int HDLC_IDLE_RUN = 15;
    localparam int UART_LEN_MIN  = 9;
    localparam int UART_LEN_MAX  = 13;

    // Restrict a programmed character length to the supported window.
    function automatic int clamp_char_len(input int len);
        if (len < UART_LEN_MIN) begin
            return UART_LEN_MIN;
        end
        if (len > UART_LEN_MAX) begin
            return UART_LEN_MAX;
        end
        return len;
    endfunction

endpackage

// File: rtl/ls_sync2.sv
module ls_sync2 #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= din;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_q[g-1];
                end
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ls_run_counter.sv
module ls_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             strobe,
    input  logic             bit_in,
    input  logic [CNT_W-1:0] threshold,
    output logic             run_met
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            count_q <= '0;
        end else if (strobe) begin
            if (!bit_in) begin
                count_q <= '0;
            end else if (count_q < threshold) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign run_met = (count_q >= threshold);

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (enable && strobe && !bit_in) |=> (count_q == '0)); // R2

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (enable && !strobe) |=> $stable(count_q)); // R4

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (enable && strobe && bit_in && run_met) |=> (run_met || !$stable(threshold))); // R4

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (count_q == '0)); // R8

endmodule

// File: rtl/ls_change_detect.sv
module ls_change_detect #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] cur_q,
    output logic             chg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            chg_q <= 1'b0;
        end else begin
            cur_q <= nxt;
            chg_q <= (nxt != cur_q);
        end
    end

    AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> (cur_q != $past(cur_q))); // R9

    AST_CHANGE_MEANS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> chg_q); // R9

endmodule

// File: rtl/line_idle_status.sv
module line_idle_status
    import line_status_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             cd_pin,
    input  logic             cts_pin,
    input  logic             mode_sel,
    input  logic             diag_soft,
    input  logic [LEN_W-1:0] char_len,
    input  logic             mux_mode,
    input  logic             rx_enable,
    input  logic             tx_enable,
    output logic             idle_stat,
    output logic             cd_stat,
    output logic             cts_stat,
    output logic             stat_change
);

    localparam int ST_W = $bits(line_status_t);

    line_mode_e       line_mode;
    diag_mode_e       diag_mode;
    logic [1:0]       pins_sync;
    logic             cd_sync;
    logic             cts_sync;
    logic [CNT_W-1:0] threshold;
    logic             line_idle;
    line_status_t     st_next;
    line_status_t     st_cur;
    logic [ST_W-1:0]  st_cur_vec;

    assign line_mode = line_mode_e'(mode_sel);
    assign diag_mode = diag_mode_e'(diag_soft);

    ls_sync2 #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cd_pin, cts_pin}),
        .dout (pins_sync)
    );

    assign cd_sync  = pins_sync[1];
    assign cts_sync = pins_sync[0];

    always_comb begin
        if (line_mode == LINE_UART) begin
            threshold = CNT_W'(clamp_char_len(int'(char_len)));
        end else begin
            threshold = CNT_W'(HDLC_IDLE_RUN);
        end
    end

    ls_run_counter #(
        .CNT_W (CNT_W)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .enable    (rx_enable),
        .strobe    (bit_en),
        .bit_in    (rx_bit),
        .threshold (threshold),
        .run_met   (line_idle)
    );

    always_comb begin
        st_next = '0;
        if (rx_enable) begin
            if (diag_mode == DIAG_NORMAL && !cd_sync) begin
                st_next.idle = 1'b1;
            end else begin
                st_next.idle = line_idle;
            end
            st_next.cd = cd_sync && !mux_mode;
        end
        st_next.cts = tx_enable && cts_sync && !mux_mode;
    end

    ls_change_detect #(
        .WIDTH (ST_W)
    ) u_chg (
        .clk   (clk),
        .rst   (rst),
        .nxt   (st_next),
        .cur_q (st_cur_vec),
        .chg_q (stat_change)
    );

    assign st_cur    = line_status_t'(st_cur_vec);
    assign idle_stat = st_cur.idle;
    assign cd_stat   = st_cur.cd;
    assign cts_stat  = st_cur.cts;

    AST_MUX_QUIET: assert property (@(posedge clk) disable iff (rst)
        mux_mode |=> (!cd_stat && !cts_stat)); // R7

    AST_NO_CARRIER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rx_enable && !diag_soft && !cd_sync) |=> idle_stat); // R5

    AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> (!idle_stat && !cd_stat)); // R8

    AST_TX_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !cts_stat); // R8

endmodule

// File: tb/line_idle_status_bench.sv
module line_idle_status_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       cd_pin = 1'b0;
    logic       cts_pin = 1'b0;
    logic       mode_sel = 1'b0;
    logic       diag_soft = 1'b0;
    logic [3:0] char_len = 4'd9;
    logic       mux_mode = 1'b0;
    logic       rx_enable = 1'b0;
    logic       tx_enable = 1'b0;
    logic       idle_stat;
    logic       cd_stat;
    logic       cts_stat;
    logic       stat_change;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    // {check_change, idle, cd, cts, change}
    logic [4:0] exp_q [$];
    string      tag_q [$];
    event       push_ev;

    always #10 clk = ~clk;

    line_idle_status u_line_idle_status (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .rx_bit      (rx_bit),
        .cd_pin      (cd_pin),
        .cts_pin     (cts_pin),
        .mode_sel    (mode_sel),
        .diag_soft   (diag_soft),
        .char_len    (char_len),
        .mux_mode    (mux_mode),
        .rx_enable   (rx_enable),
        .tx_enable   (tx_enable),
        .idle_stat   (idle_stat),
        .cd_stat     (cd_stat),
        .cts_stat    (cts_stat),
        .stat_change (stat_change)
    );

    // Monitor: drains expectations in the timestep they are pushed.
    initial begin
        forever begin
            @(push_ev);
            while (exp_q.size() != 0) begin
                logic [4:0] item;
                string      nm;
                logic [3:0] got;
                logic [3:0] want;
                item = exp_q.pop_front();
                nm   = tag_q.pop_front();
                got  = {idle_stat, cd_stat, cts_stat, stat_change};
                want = item[3:0];
                if (!item[4]) begin
                    got[0]  = 1'b0;
                    want[0] = 1'b0;
                end
                vectors++;
                if (got !== want) begin
                    miscompares++;
                    $display("FAIL %s: idle/cd/cts/chg actual=%b expected=%b", nm, got, want);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
        end
    endtask

    task automatic send_bit(input logic b);
        bit_en = 1'b1;
        rx_bit = b;
        tick();
        bit_en = 1'b0;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) begin
            send_bit(1'b1);
        end
    endtask

    task automatic expect_st(input logic i, input logic c, input logic t, input string nm);
        exp_q.push_back({1'b0, i, c, t, 1'b0});
        tag_q.push_back(nm);
        -> push_ev;
        #1;
    endtask

    task automatic expect_full(input logic i, input logic c, input logic t, input logic g,
                               input string nm);
        exp_q.push_back({1'b1, i, c, t, g});
        tag_q.push_back(nm);
        -> push_ev;
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            finish_run();
        end
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        tick();
        expect_full(0, 0, 0, 0, "R8 reset state");

        // Enables low: pins high and line idle change nothing.
        cd_pin = 1'b1;
        cts_pin = 1'b1;
        send_ones(20);
        ticks(4);
        expect_full(0, 0, 0, 0, "R8 disabled outputs");

        // Transmit enable reveals the synchronized clear-to-send.
        tx_enable = 1'b1;
        tick();
        expect_full(0, 0, 1, 1, "R9 cts rise pulse");
        tick();
        expect_full(0, 0, 1, 0, "R9 pulse one cycle");

        // Pin latency: three edges.
        cts_pin = 1'b0;
        ticks(2);
        expect_st(0, 0, 1, "R7 cts still synchronizing");
        tick();
        expect_full(0, 0, 0, 1, "R7 cts fall after three edges");

        // No carrier, normal diagnostic: idle forced.
        cd_pin = 1'b0;
        ticks(4);
        rx_enable = 1'b1;
        tick();
        expect_full(1, 0, 0, 1, "R5 no carrier forces idle");
        send_bit(1'b0);
        send_bit(1'b0);
        tick();
        expect_st(1, 0, 0, "R5 zeros ignored without carrier");

        cd_pin = 1'b1;
        ticks(3);
        expect_full(0, 1, 0, 1, "R7 carrier rise clears forced idle");

        // HDLC run of ones.
        mode_sel = 1'b0;
        send_ones(14);
        tick();
        expect_st(0, 1, 0, "R1 fourteen ones not idle");
        send_ones(1);
        tick();
        expect_st(1, 1, 0, "R1 fifteen ones idle");
        send_ones(20);
        tick();
        expect_st(1, 1, 0, "R4 saturation keeps idle");
        send_bit(1'b0);
        tick();
        expect_st(0, 1, 0, "R2 single zero clears");

        // No strobe: ones on the line do not count.
        rx_bit = 1'b1;
        ticks(40);
        expect_st(0, 1, 0, "R4 unstrobed ones ignored");

        // Flags between frames.
        for (int f = 0; f < 6; f++) begin
            send_bit(1'b0);
            send_ones(6);
            send_bit(1'b0);
            tick();
            expect_st(0, 1, 0, "R2 flags keep idle low");
        end
        send_ones(14);
        send_bit(1'b0);
        send_ones(14);
        tick();
        expect_st(0, 1, 0, "R1 broken run not idle");
        send_bit(1'b0);

        // UART character lengths.
        mode_sel = 1'b1;
        char_len = 4'd9;
        send_ones(8);
        tick();
        expect_st(0, 1, 0, "R3 eight of nine");
        send_ones(1);
        tick();
        expect_st(1, 1, 0, "R3 nine of nine");
        send_bit(1'b0);
        tick();
        expect_st(0, 1, 0, "R2 zero clears in uart");

        char_len = 4'd13;
        send_ones(12);
        tick();
        expect_st(0, 1, 0, "R3 twelve of thirteen");
        send_ones(1);
        tick();
        expect_st(1, 1, 0, "R3 thirteen of thirteen");
        send_bit(1'b0);

        char_len = 4'd4;
        send_ones(8);
        tick();
        expect_st(0, 1, 0, "R3 short length clamps to nine");
        send_ones(1);
        tick();
        expect_st(1, 1, 0, "R3 clamped nine reached");
        send_bit(1'b0);

        char_len = 4'd15;
        send_ones(12);
        tick();
        expect_st(0, 1, 0, "R3 long length clamps to thirteen");
        send_ones(1);
        tick();
        expect_st(1, 1, 0, "R3 clamped thirteen reached");
        send_bit(1'b0);
        tick();

        // Software diagnostic: carrier ignored for idle.
        diag_soft = 1'b1;
        cd_pin = 1'b0;
        ticks(3);
        expect_st(0, 0, 0, "R6 no carrier does not force idle");
        send_ones(13);
        tick();
        expect_st(1, 0, 0, "R6 idle from line only");
        send_bit(1'b0);
        tick();
        expect_st(0, 0, 0, "R6 zero clears without carrier");
        diag_soft = 1'b0;
        tick();
        expect_st(1, 0, 0, "R5 back to normal forces idle");

        // Multiplexed mode silences modem bits.
        cd_pin = 1'b1;
        cts_pin = 1'b1;
        ticks(3);
        expect_st(0, 1, 1, "R7 pins high");
        mux_mode = 1'b1;
        tick();
        expect_full(0, 0, 0, 1, "R7 mux forces zero");
        mux_mode = 1'b0;
        tick();

        // Receiver disable resets the run.
        mode_sel = 1'b0;
        send_ones(10);
        rx_enable = 1'b0;
        tick();
        expect_st(0, 0, 1, "R8 rx disable clears idle and cd");
        rx_enable = 1'b1;
        send_ones(5);
        tick();
        expect_st(0, 1, 1, "R8 run restarted after disable");
        send_ones(10);
        tick();
        expect_st(1, 1, 1, "R1 fifteen after restart");

        tick();
        finish_run();
    end

endmodule